// File: doc/BRIEF.md
# Ramp-Subtracting All-Digital Phase-Locked Loop

This block is a digital phase-locked loop that compares phase ramps rather than signal edges. A reference accumulator climbs by a reference tuning word every clock and wraps at the top of a 12-bit phase span. This gives a sawtooth whose slope is the reference frequency. A second accumulator, the numerically controlled oscillator, climbs by the loop's control word and gives the matching feedback sawtooth. A constant phase offset can be added to the reference ramp.

Each clock the detector subtracts the feedback ramp from the reference ramp. Modulo-4096 overflow wraps the difference into a signed range of -2048 to +2047. The detector scales the wrapped error by a fixed fractional gain (a multiplier over a power of two) and adds it to a centre tuning word. The saturated sum becomes the next control word. The loop has no smoothing filter, so a change in reference slope or phase reaches the oscillator on the next clock. A lock detector watches the error magnitude and counts reference ramp wraps.

In use, the integrator drives the reference word and the offset, and reads the control word as the oscillator tuning value. The lock flag gates any logic that needs a settled loop.

Top module: `dpll_ramp_core`

## Requirements
- R1: While reset is high at a clock edge, both accumulators clear to 0 (the reference ramp output then equals the phase offset), the control word loads CENTER (100 by default), and the lock flag clears.
- R2: Out of reset, the reference accumulator (reference ramp minus phase offset, modulo 4096) grows by the reference word every clock and wraps modulo 4096.
- R3: Out of reset, the oscillator ramp grows every clock by the control word it held before that edge, modulo 4096.
- R4: The phase error output equals (reference ramp − oscillator ramp) modulo 4096, read as a 12-bit two's-complement value in −2048..+2047.
- R5: Out of reset, the next control word is CENTER + floor(GAIN·err / 2^GAIN_SHIFT), where GAIN = 3 and GAIN_SHIFT = 3 by default. The result is clamped to 0 below and to 4095 above instead of wrapping.
- R6: The lock flag rises only after the error magnitude has stayed below LOCK_THRESH (64) on every clock across LOCK_COUNT (16) consecutive reference wraps. A reference wrap is a clock where the reference accumulator overflows 4096.
- R7: On any clock where the error magnitude reaches or exceeds LOCK_THRESH, the lock flag and the wrap count clear at that edge.
- R8: After the reference word steps from 100 to 102 (2 %) or to 108 (8 %), the loop regains lock within 3000 clocks. The control word then settles to within 2 of the new reference word, and the error stays below the threshold.
- R9: After a 90-degree (1024-count) phase offset step, and after a half-span (2048-count) step, the loop locks again within 3000 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_freq | input | FREQ_W (12) | Reference tuning word, ramp slope |
| phase_off | input | PHASE_W (12) | Phase offset added to the reference ramp |
| ref_ramp | output | PHASE_W (12) | Reference sawtooth including the offset |
| osc_ramp | output | PHASE_W (12) | Oscillator feedback sawtooth |
| phase_err | output | PHASE_W (12), signed | Wrapped ramp difference |
| ctrl_word | output | FREQ_W (12) | Oscillator tuning word |
| locked | output | 1 | Lock indication |

## Verification
The bench builds the core with 12-bit ramps and a centre word of 100. It uses gain 3 with a shift of 3, which keeps the loop stable with damped ringing. It selects the shift-and-add gain variant instead of the default multiplier. The low centre word means a half-span phase jump drives the control word into its lower clamp, so the saturation path is reached. The 64-count lock threshold lies well above the steady error of an 8 % step, so lock can return after each step. The sixteen-wrap lock window lasts several hundred clocks at this slope, so unlock and relock both occur inside short runs.

// File: rtl/dpll_ramp_pkg.sv
package dpll_ramp_pkg;

   // implementation choice for the loop gain scaler
   typedef enum logic {
      GAIN_MULT     = 1'b0,
      GAIN_SHIFTADD = 1'b1
   } gain_impl_e;

   // lock detector state
   typedef enum logic {
      LK_SEARCH = 1'b0,
      LK_HELD   = 1'b1
   } lock_state_e;

endpackage

// File: rtl/dpll_phase_acc.sv
module dpll_phase_acc #(
   parameter int PHASE_W = 12,
   parameter int STEP_W  = 12
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [STEP_W-1:0]  step,
   output logic [PHASE_W-1:0] phase
);

   if (STEP_W > PHASE_W) begin : g_bad_step
      $error("dpll_phase_acc: STEP_W must not exceed PHASE_W");
   end
   if (PHASE_W < 2) begin : g_bad_w
      $error("dpll_phase_acc: PHASE_W too small");
   end

   logic [PHASE_W-1:0] nxt;

   // natural overflow gives the sawtooth reset at every wrap
   assign nxt = phase + PHASE_W'(step);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
      end else begin
         phase <= nxt;
      end
   end

endmodule

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
   import dpll_ramp_pkg::*;
#(
   parameter int         PHASE_W    = 12,
   parameter int         FREQ_W     = 12,
   parameter int         CENTER     = 100,
   parameter int         GAIN       = 3,
   parameter int         GAIN_SHIFT = 3,
   parameter gain_impl_e GAIN_IMPL  = GAIN_MULT
) (
   input  logic [PHASE_W-1:0]        ref_ph,
   input  logic [PHASE_W-1:0]        fb_ph,
   output logic signed [PHASE_W-1:0] err,
   output logic [FREQ_W-1:0]         ctrl_next
);

   localparam int GW   = $clog2(GAIN + 1) + 1;
   localparam int PW   = PHASE_W + GW + 1;
   localparam int SW   = ((PW > FREQ_W) ? PW : FREQ_W) + 2;
   localparam int MAXC = (1 << FREQ_W) - 1;

   if (GAIN < 1) begin : g_bad_gain
      $error("dpll_phase_det: GAIN must be positive");
   end
   if (GAIN_SHIFT >= PW) begin : g_bad_shift
      $error("dpll_phase_det: GAIN_SHIFT too large");
   end
   if (CENTER < 0 || CENTER > MAXC) begin : g_bad_center
      $error("dpll_phase_det: CENTER outside tuning range");
   end
   if (FREQ_W > 30) begin : g_bad_fw
      $error("dpll_phase_det: FREQ_W too wide");
   end

   localparam logic signed [PW-1:0] GAIN_S = PW'(GAIN);
   localparam logic signed [SW-1:0] CTR_S  = SW'(CENTER);
   localparam logic signed [SW-1:0] MAX_S  = SW'(MAXC);

   logic [PHASE_W-1:0]       diff_u;
   logic signed [PW-1:0]     err_x;
   logic signed [PW-1:0]     scaled;
   logic signed [PW-1:0]     shifted;
   logic signed [SW-1:0]     sum;

   // subtractor; modulo wrap comes from the fixed width
   assign diff_u = ref_ph - fb_ph;
   assign err    = signed'(diff_u);
   assign err_x  = PW'(err);

   if (GAIN_IMPL == GAIN_MULT) begin : g_mult
      assign scaled = err_x * GAIN_S;
   end else begin : g_shiftadd
      logic signed [PW-1:0] part [GW+1];
      assign part[0] = '0;
      for (genvar i = 0; i < GW; i++) begin : g_term
         if (((GAIN >> i) & 1) != 0) begin : g_on
            assign part[i+1] = part[i] + (err_x <<< i);
         end else begin : g_off
            assign part[i+1] = part[i];
         end
      end
      assign scaled = part[GW];
   end

   assign shifted = scaled >>> GAIN_SHIFT;
   assign sum     = CTR_S + SW'(shifted);

   always_comb begin
      if (sum < 0) begin
         ctrl_next = '0;
      end else if (sum > MAX_S) begin
         ctrl_next = FREQ_W'(MAXC);
      end else begin
         ctrl_next = sum[FREQ_W-1:0];
      end
   end

endmodule

// File: rtl/dpll_lock_det.sv
module dpll_lock_det
   import dpll_ramp_pkg::*;
#(
   parameter int PHASE_W    = 12,
   parameter int THRESH     = 64,
   parameter int LOCK_COUNT = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic signed [PHASE_W-1:0] err,
   input  logic                      wrap_tick,
   output logic                      locked
);

   localparam int CW = $clog2(LOCK_COUNT + 1);

   if (LOCK_COUNT < 1) begin : g_bad_cnt
      $error("dpll_lock_det: LOCK_COUNT must be positive");
   end
   if (THRESH < 1 || THRESH > (1 << (PHASE_W - 1))) begin : g_bad_th
      $error("dpll_lock_det: THRESH outside error range");
   end

   localparam logic [PHASE_W:0] TH_U   = (PHASE_W+1)'(THRESH);
   localparam logic [CW-1:0]    LAST   = CW'(LOCK_COUNT - 1);
   localparam logic [CW-1:0]    FULL   = CW'(LOCK_COUNT);

   logic [PHASE_W-1:0] mag;
   logic               below;
   logic [CW-1:0]      run_cnt;
   lock_state_e        state;

   // magnitude of -2^(W-1) is correct as an unsigned W-bit value
   assign mag   = err[PHASE_W-1] ? PHASE_W'(-err) : PHASE_W'(err);
   assign below = {1'b0, mag} < TH_U;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_cnt <= '0;
         state   <= LK_SEARCH;
      end else if (!below) begin
         run_cnt <= '0;
         state   <= LK_SEARCH;
      end else if (wrap_tick) begin
         if (run_cnt != FULL) begin
            run_cnt <= run_cnt + 1'b1;
         end
         if (run_cnt == LAST) begin
            state <= LK_HELD;
         end
      end
   end

   assign locked = (state == LK_HELD);

endmodule

// File: rtl/dpll_ramp_core.sv
module dpll_ramp_core
   import dpll_ramp_pkg::*;
#(
   parameter int         PHASE_W     = 12,
   parameter int         FREQ_W      = 12,
   parameter int         CENTER      = 100,
   parameter int         GAIN        = 3,
   parameter int         GAIN_SHIFT  = 3,
   parameter gain_impl_e GAIN_IMPL   = GAIN_MULT,
   parameter int         LOCK_THRESH = 64,
   parameter int         LOCK_COUNT  = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [FREQ_W-1:0]         ref_freq,
   input  logic [PHASE_W-1:0]        phase_off,
   output logic [PHASE_W-1:0]        ref_ramp,
   output logic [PHASE_W-1:0]        osc_ramp,
   output logic signed [PHASE_W-1:0] phase_err,
   output logic [FREQ_W-1:0]         ctrl_word,
   output logic                      locked
);

   if (PHASE_W < 4) begin : g_bad_pw
      $error("dpll_ramp_core: PHASE_W too small");
   end
   if (FREQ_W > PHASE_W) begin : g_bad_fw
      $error("dpll_ramp_core: FREQ_W must not exceed PHASE_W");
   end

   logic [PHASE_W-1:0] ref_acc;
   logic [PHASE_W:0]   ref_sum;
   logic               ref_wrap;
   logic [FREQ_W-1:0]  ctrl_q;
   logic [FREQ_W-1:0]  ctrl_d;

   dpll_phase_acc #(
      .PHASE_W (PHASE_W),
      .STEP_W  (FREQ_W)
   ) u_ref_acc (
      .clk   (clk),
      .rst   (rst),
      .step  (ref_freq),
      .phase (ref_acc)
   );

   dpll_phase_acc #(
      .PHASE_W (PHASE_W),
      .STEP_W  (FREQ_W)
   ) u_osc_acc (
      .clk   (clk),
      .rst   (rst),
      .step  (ctrl_q),
      .phase (osc_ramp)
   );

   assign ref_ramp = ref_acc + phase_off;

   // reference wrap at this edge: carry out of the accumulator add
   assign ref_sum  = {1'b0, ref_acc} + (PHASE_W+1)'(ref_freq);
   assign ref_wrap = ref_sum[PHASE_W];

   dpll_phase_det #(
      .PHASE_W    (PHASE_W),
      .FREQ_W     (FREQ_W),
      .CENTER     (CENTER),
      .GAIN       (GAIN),
      .GAIN_SHIFT (GAIN_SHIFT),
      .GAIN_IMPL  (GAIN_IMPL)
   ) u_det (
      .ref_ph    (ref_ramp),
      .fb_ph     (osc_ramp),
      .err       (phase_err),
      .ctrl_next (ctrl_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= FREQ_W'(CENTER);
      end else begin
         ctrl_q <= ctrl_d;
      end
   end

   assign ctrl_word = ctrl_q;

   dpll_lock_det #(
      .PHASE_W    (PHASE_W),
      .THRESH     (LOCK_THRESH),
      .LOCK_COUNT (LOCK_COUNT)
   ) u_lock (
      .clk       (clk),
      .rst       (rst),
      .err       (phase_err),
      .wrap_tick (ref_wrap),
      .locked    (locked)
   );

endmodule

// File: rtl/dpll_ramp_chk.sv
module dpll_ramp_chk #(
   parameter int PHASE_W     = 12,
   parameter int FREQ_W      = 12,
   parameter int CENTER      = 100,
   parameter int GAIN        = 3,
   parameter int GAIN_SHIFT  = 3,
   parameter int LOCK_THRESH = 64
) (
   input logic                      clk,
   input logic                      rst,
   input logic [FREQ_W-1:0]         ref_freq,
   input logic [PHASE_W-1:0]        phase_off,
   input logic [PHASE_W-1:0]        ref_ramp,
   input logic [PHASE_W-1:0]        osc_ramp,
   input logic signed [PHASE_W-1:0] phase_err,
   input logic [FREQ_W-1:0]         ctrl_word,
   input logic                      locked
);

   localparam int MAXC = (1 << FREQ_W) - 1;

   logic rst_q = 1'b0;
   always_ff @(posedge clk) rst_q <= rst;

   function automatic int law(int e);
      int v;
      v = CENTER + ((GAIN * e) >>> GAIN_SHIFT);
      if (v < 0) v = 0;
      if (v > MAXC) v = MAXC;
      return v;
   endfunction

   function automatic int mag(int e);
      return (e < 0) ? -e : e;
   endfunction

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst_q |-> (ctrl_word == FREQ_W'(CENTER)) && !locked && (osc_ramp == '0));

   // R2
   ref_advance_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> PHASE_W'(ref_ramp - phase_off) ==
         PHASE_W'($past(PHASE_W'(ref_ramp - phase_off)) + $past(PHASE_W'(ref_freq))));

   // R3
   osc_advance_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> osc_ramp == PHASE_W'($past(osc_ramp) + $past(PHASE_W'(ctrl_word))));

   // R5
   ctrl_law_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> int'(ctrl_word) == law($past(int'(phase_err))));

   // R7
   lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (mag(int'(phase_err)) >= LOCK_THRESH) |=> !locked);

   // R6
   lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(mag(int'(phase_err)) < LOCK_THRESH));

endmodule

bind dpll_ramp_core dpll_ramp_chk #(
   .PHASE_W     (PHASE_W),
   .FREQ_W      (FREQ_W),
   .CENTER      (CENTER),
   .GAIN        (GAIN),
   .GAIN_SHIFT  (GAIN_SHIFT),
   .LOCK_THRESH (LOCK_THRESH)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ref_freq  (ref_freq),
   .phase_off (phase_off),
   .ref_ramp  (ref_ramp),
   .osc_ramp  (osc_ramp),
   .phase_err (phase_err),
   .ctrl_word (ctrl_word),
   .locked    (locked)
);

// File: tb/dpll_ramp_core_test.sv
module dpll_ramp_core_test;
   import dpll_ramp_pkg::*;

   localparam int PW  = 12;
   localparam int FW  = 12;
   localparam int CTR = 100;
   localparam int GN  = 3;
   localparam int GS  = 3;
   localparam int TH  = 64;
   localparam int LC  = 16;
   localparam int SPAN = 1 << PW;
   localparam int MAXC = (1 << FW) - 1;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic [FW-1:0]        ref_freq = FW'(CTR);
   logic [PW-1:0]        phase_off = '0;
   logic [PW-1:0]        ref_ramp;
   logic [PW-1:0]        osc_ramp;
   logic signed [PW-1:0] phase_err;
   logic [FW-1:0]        ctrl_word;
   logic                 locked;

   always #4 clk = ~clk;

   dpll_ramp_core #(
      .PHASE_W     (PW),
      .FREQ_W      (FW),
      .CENTER      (CTR),
      .GAIN        (GN),
      .GAIN_SHIFT  (GS),
      .GAIN_IMPL   (GAIN_SHIFTADD),
      .LOCK_THRESH (TH),
      .LOCK_COUNT  (LC)
   ) uut (
      .clk       (clk),
      .rst       (rst),
      .ref_freq  (ref_freq),
      .phase_off (phase_off),
      .ref_ramp  (ref_ramp),
      .osc_ramp  (osc_ramp),
      .phase_err (phase_err),
      .ctrl_word (ctrl_word),
      .locked    (locked)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   // behavioural loop model
   int m_ref  = 0;
   int m_osc  = 0;
   int m_ctrl = CTR;
   int m_run  = 0;
   bit m_lock = 0;

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic int model_err();
      int d;
      d = ((m_ref + int'(phase_off)) - m_osc) % SPAN;
      if (d < 0) d += SPAN;
      if (d >= SPAN / 2) d -= SPAN;
      return d;
   endfunction

   function automatic int absv(int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic cycle();
      int e, nr, no, nc, nrun;
      bit nl, wr;
      e = model_err();
      if (rst) begin
         nr = 0; no = 0; nc = CTR; nrun = 0; nl = 0;
      end else begin
         wr = (m_ref + int'(ref_freq)) >= SPAN;
         nr = (m_ref + int'(ref_freq)) % SPAN;
         no = (m_osc + m_ctrl) % SPAN;
         nc = CTR + ((GN * e) >>> GS);
         if (nc < 0) nc = 0;
         if (nc > MAXC) nc = MAXC;
         nrun = m_run; nl = m_lock;
         if (absv(e) >= TH) begin
            nrun = 0; nl = 0;
         end else if (wr) begin
            if (m_run == LC - 1) nl = 1;
            if (m_run != LC) nrun = m_run + 1;
         end
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
      m_ref = nr; m_osc = no; m_ctrl = nc; m_run = nrun; m_lock = nl;
      check("R2 ref_ramp", int'(ref_ramp), (m_ref + int'(phase_off)) % SPAN);
      check("R3 osc_ramp", int'(osc_ramp), m_osc);
      check("R4 phase_err", int'(phase_err), model_err());
      check("R5 ctrl_word", int'(ctrl_word), m_ctrl);
      check("R6/R7 locked", int'(locked), int'(m_lock));
   endtask

   task automatic wait_lock(string tag, int limit);
      int n = 0;
      while (!locked && n < limit) begin
         cycle();
         n++;
      end
      check(tag, int'(locked), 1);
   endtask

   task automatic settle_check(string tag, int target);
      repeat (300) cycle();
      check({tag, " ctrl near target"}, int'(absv(int'(ctrl_word) - target) <= 2), 1);
      check({tag, " error under threshold"}, int'(absv(int'(phase_err)) < TH), 1);
      check({tag, " still locked"}, int'(locked), 1);
   endtask

   // watchdog
   always @(posedge clk) begin
      if (!done && cyc > 60000) begin
         n_bad++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      @(negedge clk);
      repeat (3) cycle();
      check("R1 ref_ramp in reset", int'(ref_ramp), 0);
      check("R1 osc_ramp in reset", int'(osc_ramp), 0);
      check("R1 ctrl_word in reset", int'(ctrl_word), CTR);
      check("R1 locked in reset", int'(locked), 0);
      rst = 1'b0;

      // R6: nominal reference equals centre, error stays zero
      wait_lock("R6 lock at nominal", 2000);

      // R8: 2 % step
      ref_freq = FW'(102);
      wait_lock("R8 lock after step to 102", 3000);
      settle_check("R8 step 102", 102);

      // R8: 8 % step
      ref_freq = FW'(108);
      wait_lock("R8 lock after step to 108", 3000);
      settle_check("R8 step 108", 108);

      // R7 and R9: quarter-span phase jump
      phase_off = phase_off + PW'(1024);
      cycle();
      check("R7 lock drops on phase jump", int'(locked), 0);
      wait_lock("R9 relock after 90 deg", 3000);
      settle_check("R9 after 90 deg", 108);

      // R5 saturation and R9: half-span jump drives the control word to 0
      phase_off = phase_off + PW'(2048);
      cycle();
      check("R5 ctrl clamps at zero", int'(ctrl_word), 0);
      check("R7 lock drops on half-span jump", int'(locked), 0);
      wait_lock("R9 relock after half span", 3000);
      settle_check("R9 after half span", 108);

      // R1: reset in mid-run restores the initial state
      rst = 1'b1;
      cycle();
      check("R1 ctrl after late reset", int'(ctrl_word), CTR);
      check("R1 lock after late reset", int'(locked), 0);
      check("R1 osc after late reset", int'(osc_ramp), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule